// File: doc/BRIEF.md
# Port-Change Interrupt Generator

This block watches a wide vector of input pin levels and raises an active-low interrupt request whenever the synchronized levels stop matching a stored reference copy. Comparing against a level copy, instead of latching edges, lets the request withdraw by itself when the pins drift back to the stored pattern. Once a mismatch has lasted a programmable number of clock cycles, the request is driven. This stands in for the fixed settling time that elapses before the interrupt line is valid.

A host access also withdraws the request and refreshes the reference from the pins as they are at that moment. Two kinds of access do this: the rising edge of the pulse that marks an acknowledged read byte, or a phase of the write-to-port strobe. The strobe's falling phase always clears. Its rising phase also clears when a parameter selects that. For a short window after each clear, the reference keeps following the pins, so changes that arrive inside that window are absorbed and do not raise a request. After the window ends, any difference is detected again.

The block sits between the pad synchronizers and the open-drain pad driver of a remote I/O expander. The bus protocol engine supplies the read and write strobes. The output drives the interrupt pad: low means the request is asserted.

Top module: `port_change_irq`

## Requirements
- R1: While `rst_n` is low, the reference loads the synchronized pins and `irq_n_o` is high. After release, `irq_n_o` stays high for as long as the pins keep the levels they had during reset.
- R2: Flip any single pin, in either direction, after a negative clock edge. `irq_n_o` goes low at the `SYNC_STAGES + VALID_DLY`-th rising edge after that, and not at any earlier edge.
- R3: When the synchronized pins equal the reference again, `irq_n_o` returns high at the `SYNC_STAGES + 1`-th rising edge after the pin change, with no host access. A mismatch that lasts fewer than `VALID_DLY` cycles at the comparator never drives the request.
- R4: A rising edge on `rd_ack_i` (sampled low, then high) releases `irq_n_o` at that same clock edge and reloads the reference. Pin levels present at that moment then raise no request.
- R5: A falling edge on `wr_strobe_i` always releases `irq_n_o` at the edge where it is sampled. A rising edge releases it only when `WR_CLEAR_ON_RISE` is 1; when it is 0, a rising edge has no effect.
- R6: The reference keeps tracking the synchronized pins in the clear cycle and in the `BLIND_CYCLES` cycles after it. A pin change that reaches the comparator inside that window never raises a request, and a change made after the window is detected as in R2.
- R7: `irq_n_o` stays low while at least one bit still differs, even if some of several changed bits return to their reference value.
- R8: Only the rising edge of `rd_ack_i` clears. If `rd_ack_i` is held high, a pin change made after the blind window still drives the request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pin_i | input | WIDTH | Raw pin levels, asynchronous to `clk` |
| rd_ack_i | input | 1 | High while a read-from-port byte is being acknowledged; its rising edge clears |
| wr_strobe_i | input | 1 | Write-to-port strobe; falling edge clears, rising edge optionally clears |
| irq_n_o | output | 1 | Interrupt request, low when asserted |

## Verification
Every one of the 48 pins is flipped on its own, first one way and then back. This shows that each bit reaches the comparator, that both polarities are caught, and that the assertion edge falls exactly on the expected cycle. Read clears and write clears alternate from bit to bit. Two instances run side by side, one for each setting of the write-rise option, so that an early clear can be told apart from a clear that only comes on the strobe's falling phase. The remaining patterns each separate one behaviour from a similar one:
- a two-cycle glitch shows that the settling delay filters short mismatches;
- a two-bit change followed by a partial revert shows that the request tracks any remaining difference;
- a change made right after a clear falls inside the blind window;
- a change made while the read strobe is held high shows that clearing is triggered by the edge, not the level.

// File: rtl/pcg_pkg.sv
package pcg_pkg;

   typedef enum logic [1:0] {
      EDGE_NONE = 2'd0,
      EDGE_RISE = 2'd1,
      EDGE_FALL = 2'd2
   } edge_e;

   function automatic edge_e edge_of(input logic prev, input logic cur);
      if (!prev && cur)      return EDGE_RISE;
      else if (prev && !cur) return EDGE_FALL;
      else                   return EDGE_NONE;
   endfunction

   function automatic int cnt_width(input int limit);
      if (limit <= 1) return 1;
      return $clog2(limit + 1);
   endfunction

endpackage

// File: rtl/pcg_sync.sv
module pcg_sync #(
   parameter int WIDTH  = 48,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic [WIDTH-1:0] async_i,
   output logic [WIDTH-1:0] sync_o
);

   if (STAGES < 2) begin : g_bad_stages
      $error("pcg_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0][WIDTH-1:0] stage_q;

   // Free-running chain: no reset, so the reference can load real levels during reset.
   always_ff @(posedge clk) begin
      stage_q <= {stage_q[STAGES-2:0], async_i};
   end

   assign sync_o = stage_q[STAGES-1];

endmodule

// File: rtl/pcg_clear_ctl.sv
module pcg_clear_ctl
   import pcg_pkg::*;
#(
   parameter int BLIND_CYCLES     = 3,
   parameter bit WR_CLEAR_ON_RISE = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic rd_ack_i,
   input  logic wr_strobe_i,
   output logic clr_o,
   output logic blind_o
);

   if (BLIND_CYCLES < 0) begin : g_bad_blind
      $error("pcg_clear_ctl: BLIND_CYCLES must not be negative");
   end

   logic  rd_prev_q, wr_prev_q;
   edge_e rd_edge, wr_edge;
   logic  wr_clear;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_prev_q <= 1'b0;
         wr_prev_q <= 1'b0;
      end else begin
         rd_prev_q <= rd_ack_i;
         wr_prev_q <= wr_strobe_i;
      end
   end

   assign rd_edge = edge_of(rd_prev_q, rd_ack_i);
   assign wr_edge = edge_of(wr_prev_q, wr_strobe_i);

   if (WR_CLEAR_ON_RISE) begin : g_wr_both
      assign wr_clear = (wr_edge == EDGE_RISE) || (wr_edge == EDGE_FALL);
   end else begin : g_wr_fall
      assign wr_clear = (wr_edge == EDGE_FALL);
   end

   assign clr_o = (rd_edge == EDGE_RISE) || wr_clear;

   if (BLIND_CYCLES == 0) begin : g_no_blind
      assign blind_o = 1'b0;
   end else begin : g_blind
      localparam int BW = cnt_width(BLIND_CYCLES);
      logic [BW-1:0] blind_q;

      always_ff @(posedge clk) begin
         if (!rst_n)               blind_q <= '0;
         else if (clr_o)           blind_q <= BW'(BLIND_CYCLES);
         else if (blind_q != '0)   blind_q <= blind_q - 1'b1;
      end

      assign blind_o = (blind_q != '0);

      // R6: the window never outlasts its programmed length
      a_r6_blind_bounded: assert property (@(posedge clk) disable iff (!rst_n)
         (blind_q == BW'(BLIND_CYCLES)) && !clr_o |=> blind_q < BW'(BLIND_CYCLES));
   end

   // R8: a level held high on the read strobe produces a single clear
   a_r8_read_edge_only: assert property (@(posedge clk) disable iff (!rst_n)
      rd_ack_i && $past(rd_ack_i) && !wr_strobe_i && !$past(wr_strobe_i) |-> !clr_o);

endmodule

// File: rtl/pcg_detect.sv
module pcg_detect
   import pcg_pkg::*;
#(
   parameter int WIDTH     = 48,
   parameter int VALID_DLY = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] sync_i,
   input  logic             clr_i,
   input  logic             blind_i,
   output logic             irq_o,
   output logic             diff_o
);

   if (WIDTH < 1) begin : g_bad_width
      $error("pcg_detect: WIDTH must be at least 1");
   end
   if (VALID_DLY < 1) begin : g_bad_dly
      $error("pcg_detect: VALID_DLY must be at least 1");
   end

   localparam int CW = cnt_width(VALID_DLY);
   localparam logic [CW-1:0] LAST = CW'(VALID_DLY - 1);

   logic [WIDTH-1:0] ref_q;
   logic [CW-1:0]    cnt_q;
   logic             irq_q;

   assign diff_o = |(sync_i ^ ref_q);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ref_q <= sync_i;
         cnt_q <= '0;
         irq_q <= 1'b0;
      end else if (clr_i || blind_i) begin
         ref_q <= sync_i;
         cnt_q <= '0;
         irq_q <= 1'b0;
      end else if (!diff_o) begin
         cnt_q <= '0;
         irq_q <= 1'b0;
      end else if (!irq_q) begin
         if (cnt_q == LAST) begin
            irq_q <= 1'b1;
            cnt_q <= '0;
         end else begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end

   assign irq_o = irq_q;

   // R2: a request only appears after a mismatch was seen
   a_r2_rise_needs_diff: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_q) |-> $past(diff_o));

   // R3: once the pins match the reference the request is withdrawn
   a_r3_match_releases: assert property (@(posedge clk) disable iff (!rst_n)
      !diff_o |=> !irq_q);

   // R4: any clear releases the request at the next sample
   a_r4_clear_releases: assert property (@(posedge clk) disable iff (!rst_n)
      clr_i |=> !irq_q);

   // R6: no request can start inside the blind window
   a_r6_blind_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      blind_i |=> !irq_q);

endmodule

// File: rtl/port_change_irq.sv
module port_change_irq #(
   parameter int WIDTH            = 48,
   parameter int SYNC_STAGES      = 2,
   parameter int VALID_DLY        = 4,
   parameter int BLIND_CYCLES     = 3,
   parameter bit WR_CLEAR_ON_RISE = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] pin_i,
   input  logic             rd_ack_i,
   input  logic             wr_strobe_i,
   output logic             irq_n_o
);

   logic [WIDTH-1:0] pin_sync;
   logic             clr, blind, irq, diff;

   pcg_sync #(
      .WIDTH  (WIDTH),
      .STAGES (SYNC_STAGES)
   ) u_sync (
      .clk     (clk),
      .async_i (pin_i),
      .sync_o  (pin_sync)
   );

   pcg_clear_ctl #(
      .BLIND_CYCLES     (BLIND_CYCLES),
      .WR_CLEAR_ON_RISE (WR_CLEAR_ON_RISE)
   ) u_clear (
      .clk         (clk),
      .rst_n       (rst_n),
      .rd_ack_i    (rd_ack_i),
      .wr_strobe_i (wr_strobe_i),
      .clr_o       (clr),
      .blind_o     (blind)
   );

   pcg_detect #(
      .WIDTH     (WIDTH),
      .VALID_DLY (VALID_DLY)
   ) u_detect (
      .clk     (clk),
      .rst_n   (rst_n),
      .sync_i  (pin_sync),
      .clr_i   (clr),
      .blind_i (blind),
      .irq_o   (irq),
      .diff_o  (diff)
   );

   assign irq_n_o = ~irq;

   // R1: the line is released as reset ends
   a_r1_reset_released: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> irq_n_o);

   // R5: the falling write phase always releases the line
   a_r5_write_fall_clears: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(wr_strobe_i) |=> irq_n_o);

   // R7: while any bit differs outside a clear, the line does not rise spontaneously
   a_r7_hold_while_diff: assert property (@(posedge clk) disable iff (!rst_n)
      !irq_n_o && diff && !clr && !blind |=> !irq_n_o);

endmodule

// File: tb/port_change_irq_test.sv
module port_change_irq_test;

   localparam int CLK_PERIOD = 10;
   localparam int W     = 48;
   localparam int SYNC  = 2;
   localparam int DLY   = 4;
   localparam int BLIND = 3;

   logic         clk = 1'b0;
   logic         rst_n;
   logic [W-1:0] pins;
   logic         rd, wr;
   logic         irq_a_n, irq_b_n;
   logic [W-1:0] base;
   int           n_cmp = 0;
   int           n_bad = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   port_change_irq #(
      .WIDTH(W), .SYNC_STAGES(SYNC), .VALID_DLY(DLY),
      .BLIND_CYCLES(BLIND), .WR_CLEAR_ON_RISE(1'b1)
   ) uut (
      .clk(clk), .rst_n(rst_n), .pin_i(pins),
      .rd_ack_i(rd), .wr_strobe_i(wr), .irq_n_o(irq_a_n)
   );

   port_change_irq #(
      .WIDTH(W), .SYNC_STAGES(SYNC), .VALID_DLY(DLY),
      .BLIND_CYCLES(BLIND), .WR_CLEAR_ON_RISE(1'b0)
   ) uut_fall (
      .clk(clk), .rst_n(rst_n), .pin_i(pins),
      .rd_ack_i(rd), .wr_strobe_i(wr), .irq_n_o(irq_b_n)
   );

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic check(input logic act, input logic exp, input string tag);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s at %0t: actual %b expected %b", tag, $time, act, exp);
      end
   endtask

   task automatic check_both(input logic exp, input string tag);
      check(irq_a_n, exp, {tag, " rise-option"});
      check(irq_b_n, exp, {tag, " fall-only"});
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      rst_n = 1'b0;
      rd    = 1'b0;
      wr    = 1'b0;
      pins  = 48'hA5A5_0F0F_3C3C;
      tick(5);
      rst_n = 1'b1;
      tick(DLY + 4);
      check_both(1'b1, "R1 reset quiet");
      base = pins;

      // Per-bit sweep, both directions, alternating read and write clears
      for (int i = 0; i < W; i++) begin
         pins = base ^ (48'd1 << i);
         tick(SYNC + DLY - 1);
         check_both(1'b1, $sformatf("R2 bit%0d not early", i));
         tick(1);
         check_both(1'b0, $sformatf("R2 bit%0d asserted", i));
         if (i % 2 == 0) begin
            rd = 1'b1;
            tick(1);
            rd = 1'b0;
            check_both(1'b1, $sformatf("R4 bit%0d read clear", i));
         end else begin
            wr = 1'b1;
            tick(1);
            check(irq_a_n, 1'b1, $sformatf("R5 bit%0d rise clears", i));
            check(irq_b_n, 1'b0, $sformatf("R5 bit%0d rise ignored", i));
            tick(1);
            wr = 1'b0;
            tick(1);
            check(irq_b_n, 1'b1, $sformatf("R5 bit%0d fall clears", i));
         end
         tick(DLY + 3);
         check_both(1'b1, $sformatf("R4 bit%0d snapshot reloaded", i));
         pins = base;
         tick(SYNC + DLY - 1);
         check_both(1'b1, $sformatf("R2 bit%0d back not early", i));
         tick(1);
         check_both(1'b0, $sformatf("R2 bit%0d back asserted", i));
         pins = base ^ (48'd1 << i);
         tick(SYNC);
         check_both(1'b0, $sformatf("R3 bit%0d still low", i));
         tick(1);
         check_both(1'b1, $sformatf("R3 bit%0d self release", i));
         base = pins;
      end

      // R3: glitch shorter than the settling delay
      pins = base ^ (48'd1 << 5);
      tick(2);
      pins = base;
      tick(DLY + 4);
      check_both(1'b1, "R3 short glitch filtered");

      // R7: two bits change, one reverts
      pins = base ^ (48'd1 << 0) ^ (48'd1 << 47);
      tick(SYNC + DLY);
      check_both(1'b0, "R7 two bits asserted");
      pins = base ^ (48'd1 << 0);
      tick(4);
      check_both(1'b0, "R7 partial revert holds");
      pins = base;
      tick(SYNC + 1);
      check_both(1'b1, "R3 full revert releases");

      // R6: change right after a clear is absorbed, later change is seen
      rd = 1'b1;
      tick(1);
      rd = 1'b0;
      pins = base ^ (48'd1 << 7);
      tick(DLY + 6);
      check_both(1'b1, "R6 change in window absorbed");
      base = pins;
      pins = base ^ (48'd1 << 8);
      tick(SYNC + DLY - 1);
      check_both(1'b1, "R6 after window not early");
      tick(1);
      check_both(1'b0, "R6 after window detected");

      // R8: read strobe held high clears once only
      rd = 1'b1;
      tick(1);
      check_both(1'b1, "R8 first edge clears");
      tick(BLIND + 1);
      base = pins;
      pins = base ^ (48'd1 << 9);
      tick(SYNC + DLY - 1);
      check_both(1'b1, "R8 held read not early");
      tick(1);
      check_both(1'b0, "R8 held read does not mask");
      rd = 1'b0;
      tick(1);
      rd = 1'b1;
      tick(1);
      rd = 1'b0;
      check_both(1'b1, "R4 new read edge clears");

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule